// File: doc/BRIEF.md
# Serial Command Byte Register Decoder

This block is the register front end of a mixed-signal converter's serial slave port. A host frames each transaction with an active-low select and clocks bits in MSB first on a serial clock. The first byte of a frame is a command. Its upper bits name a target register: the conversion command register, the setup register, or one of two per-pair mode masks that follow a setup byte. It can also start a word for the DAC interface or a GPIO write. Any data bytes that the command calls for are gathered and written to the named register. After a command's last byte, the next byte is parsed as a fresh command, so one frame can carry several commands.

Every input is sampled on the block's own system clock. The serial clock and select are edge-detected inside the block and are never used as clocks. The DAC word is passed out on a separate port with a one-cycle strobe. GPIO direction and level change only when the select rises, and only if a complete GPIO word was received. The data output echoes the previous byte of the same frame, so a host can confirm what the block received.

Top module: `spi_cmd_decoder`

## Requirements
- R1: A command byte with bit 7 set is copied whole into `conv_cmd`. After reset `conv_cmd` is 0.
- R2: A command byte of the form 01xxxxxx loads its bits 5:0 into `setup_cfg`. Bits 5:4 are the clock mode, bits 3:2 the reference mode and bits 1:0 the mode-mask select. After reset `setup_cfg` is 6'b100000, so the upper clock-mode bit is 1.
- R3: When the setup byte's bits 1:0 are 10, the next byte of the frame is written to `uni_mask`. Bit 7 covers input pair 0/1, bit 6 covers pair 2/3, and so on down to bit 0.
- R4: When the setup byte's bits 1:0 are 11, the next byte of the frame is written to `bip_mask`, using the same bit-to-pair order as R3.
- R5: When the setup byte's bits 1:0 are 00 or 01, neither mask is written and the next byte is parsed as a command.
- R6: A command byte 0001xxxx, with the low nibble ignored, takes the next DAC_W bits MSB first. They appear on `dac_word`, with `dac_valid` high for exactly one clock once the last bit arrives.
- R7: The command byte 00000010 takes the next 2*GPIO_W bits. The upper half is direction (1 = output) and the lower half is level. `gpio_dir` and `gpio_lvl` change only on the rising edge of `cs_n` that ends the frame. Both are 0 after reset, so all pins start as inputs.
- R8: Raising `cs_n` part-way through a byte or a data word discards the partial data. A GPIO word that is not complete is never applied. The first byte of the next frame is parsed as a command.
- R9: Command bytes matching none of the codes above (00000000, 00000001, 00000011 to 00001111, 001xxxxx) change no register and start no data phase.
- R10: `mosi` is sampled on rising `sclk` edges, MSB first. `miso` changes after falling edges and carries the previous byte of the frame MSB first. It is 0 during a frame's first byte and whenever `cs_n` is high.
- R11: After a command's data bytes are complete, further bytes in the same frame are parsed as new commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, sampled on clk |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out, echo of previous byte |
| conv_cmd | output | 8 | Conversion command register |
| setup_cfg | output | 6 | Setup fields: clock mode, reference mode, mask select |
| uni_mask | output | 8 | Unipolar pair mask |
| bip_mask | output | 8 | Bipolar pair mask |
| dac_word | output | DAC_W | Last word routed to the DAC interface |
| dac_valid | output | 1 | One-clock strobe for a new dac_word |
| gpio_dir | output | GPIO_W | GPIO direction, 1 = output |
| gpio_lvl | output | GPIO_W | GPIO output level |

## Verification
Random frames of one to six bytes are built from a biased mix of every command class, random setup mask selects and arbitrary data. This checks that the decoder follows the byte count each command implies and treats chained commands within a frame correctly. Directed frames isolate the cases the random mix reaches rarely:
- a setup byte whose mask phase is cut short by the select rising;
- a few stray bits before the select rises, which shows whether a partial byte leaks into the next frame's decode;
- a GPIO word that is read back while the select is still low, which separates commit-on-select-rise from commit-on-last-bit;
- a GPIO word that is not complete.

The echo on `miso` is compared for every byte, which shows both the bit order and the falling-edge timing.

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder #(
  parameter int GPIO_W = 8,
  parameter int DAC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              mosi,
  output logic              miso,
  output logic [7:0]        conv_cmd,
  output logic [5:0]        setup_cfg,
  output logic [7:0]        uni_mask,
  output logic [7:0]        bip_mask,
  output logic [DAC_W-1:0]  dac_word,
  output logic              dac_valid,
  output logic [GPIO_W-1:0] gpio_dir,
  output logic [GPIO_W-1:0] gpio_lvl
);
  localparam int GW_BITS = 2 * GPIO_W;
  localparam int DAC_BYTES = DAC_W / 8;
  localparam int GPIO_BYTES = GW_BITS / 8;
  localparam int MAXB = (DAC_BYTES > GPIO_BYTES) ? DAC_BYTES : GPIO_BYTES;
  localparam int CW = $clog2(MAXB) + 1;

  typedef enum logic [2:0] {S_CMD, S_UNI, S_BIP, S_DAC, S_GPIO} st_t;

  st_t                st;
  logic               sclk_q, cs_q;
  logic [2:0]         bitcnt;
  logic [6:0]         sh;
  logic [CW-1:0]      left;
  logic [DAC_W-1:0]   dac_acc;
  logic [GW_BITS-1:0] gpio_acc, gpio_new;
  logic               gpio_pend;
  logic [7:0]         last, osh;
  logic               load_pend;

  wire       rise  = !cs_n && sclk && !sclk_q;
  wire       fall  = !cs_n && !sclk && sclk_q;
  wire       cs_up = cs_n && !cs_q;
  wire [7:0] rx    = {sh, mosi};
  wire       done  = rise && (bitcnt == 3'd7);

  assign miso = !cs_n && osh[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_CMD;
      sclk_q    <= 1'b0;
      cs_q      <= 1'b1;
      bitcnt    <= '0;
      sh        <= '0;
      left      <= '0;
      dac_acc   <= '0;
      gpio_acc  <= '0;
      gpio_new  <= '0;
      gpio_pend <= 1'b0;
      last      <= '0;
      osh       <= '0;
      load_pend <= 1'b0;
      conv_cmd  <= '0;
      setup_cfg <= 6'b100000;
      uni_mask  <= '0;
      bip_mask  <= '0;
      dac_word  <= '0;
      dac_valid <= 1'b0;
      gpio_dir  <= '0;
      gpio_lvl  <= '0;
    end else begin
      sclk_q    <= sclk;
      cs_q      <= cs_n;
      dac_valid <= 1'b0;
      if (cs_n) begin
        st        <= S_CMD;
        bitcnt    <= '0;
        osh       <= '0;
        load_pend <= 1'b0;
        if (cs_up && gpio_pend) begin
          {gpio_dir, gpio_lvl} <= gpio_new;
          gpio_pend            <= 1'b0;
        end
      end else begin
        if (rise) begin
          bitcnt <= bitcnt + 3'd1;
          sh     <= {sh[5:0], mosi};
        end
        if (fall) begin
          if (load_pend) begin
            osh       <= last;
            load_pend <= 1'b0;
          end else begin
            osh <= {osh[6:0], 1'b0};
          end
        end
        if (done) begin
          last      <= rx;
          load_pend <= 1'b1;
          case (st)
            S_CMD: begin
              if (rx[7]) begin
                conv_cmd <= rx;
              end else if (rx[6]) begin
                setup_cfg <= rx[5:0];
                case (rx[1:0])
                  2'b10:   st <= S_UNI;
                  2'b11:   st <= S_BIP;
                  default: st <= S_CMD;
                endcase
              end else if (rx[7:4] == 4'b0001) begin
                st   <= S_DAC;
                left <= CW'(DAC_BYTES - 1);
              end else if (rx == 8'h02) begin
                st        <= S_GPIO;
                left      <= CW'(GPIO_BYTES - 1);
                gpio_pend <= 1'b0;
              end
            end
            S_UNI: begin
              uni_mask <= rx;
              st       <= S_CMD;
            end
            S_BIP: begin
              bip_mask <= rx;
              st       <= S_CMD;
            end
            S_DAC: begin
              dac_acc <= {dac_acc[DAC_W-9:0], rx};
              if (left == '0) begin
                dac_word  <= {dac_acc[DAC_W-9:0], rx};
                dac_valid <= 1'b1;
                st        <= S_CMD;
              end else begin
                left <= left - CW'(1);
              end
            end
            S_GPIO: begin
              gpio_acc <= {gpio_acc[GW_BITS-9:0], rx};
              if (left == '0) begin
                gpio_new  <= {gpio_acc[GW_BITS-9:0], rx};
                gpio_pend <= 1'b1;
                st        <= S_CMD;
              end else begin
                left <= left - CW'(1);
              end
            end
            default: st <= S_CMD;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/spi_cmd_decoder_chk.sv
module spi_cmd_decoder_chk #(
  parameter int GPIO_W = 8,
  parameter int DAC_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              miso,
  input logic [7:0]        conv_cmd,
  input logic [5:0]        setup_cfg,
  input logic [7:0]        uni_mask,
  input logic [7:0]        bip_mask,
  input logic [DAC_W-1:0]  dac_word,
  input logic              dac_valid,
  input logic [GPIO_W-1:0] gpio_dir,
  input logic [GPIO_W-1:0] gpio_lvl
);
  AST_GPIO_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cs_n) |-> ($stable(gpio_dir) && $stable(gpio_lvl))); // R7

  AST_DAC_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid |=> !dac_valid); // R6

  AST_DAC_STROBE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(dac_word) |-> (dac_valid && !$past(cs_n))); // R6

  AST_REGS_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> ($stable(conv_cmd) && $stable(setup_cfg) &&
                     $stable(uni_mask) && $stable(bip_mask))); // R8

  AST_MISO_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> !miso); // R10

  AST_INPUTS_AFTER_RESET: assert property (@(posedge clk)
    $rose(rst_n) |-> (gpio_dir == '0)); // R7
endmodule

bind spi_cmd_decoder spi_cmd_decoder_chk #(.GPIO_W(GPIO_W), .DAC_W(DAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso(miso),
  .conv_cmd(conv_cmd), .setup_cfg(setup_cfg), .uni_mask(uni_mask),
  .bip_mask(bip_mask), .dac_word(dac_word), .dac_valid(dac_valid),
  .gpio_dir(gpio_dir), .gpio_lvl(gpio_lvl)
);

// File: tb/tb_spi_cmd_decoder.sv
module tb_spi_cmd_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic mosi = 1'b0;
  logic miso;
  logic [7:0]  conv_cmd, uni_mask, bip_mask;
  logic [5:0]  setup_cfg;
  logic [15:0] dac_word;
  logic        dac_valid;
  logic [7:0]  gpio_dir, gpio_lvl;

  always #10 clk = ~clk;

  spi_cmd_decoder #(.GPIO_W(8), .DAC_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso),
    .conv_cmd(conv_cmd), .setup_cfg(setup_cfg), .uni_mask(uni_mask),
    .bip_mask(bip_mask), .dac_word(dac_word), .dac_valid(dac_valid),
    .gpio_dir(gpio_dir), .gpio_lvl(gpio_lvl)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  int          dac_seen = 0;
  logic [15:0] dac_last = '0;
  always @(posedge clk) if (rst_n && dac_valid) begin
    dac_seen++;
    dac_last = dac_word;
  end

  logic [7:0]  e_conv = 8'h00, e_uni = 8'h00, e_bip = 8'h00;
  logic [5:0]  e_setup = 6'b100000;
  logic [15:0] e_dac = 16'h0000, m_acc = 16'h0000, e_gnew = 16'h0000;
  logic [7:0]  e_dir = 8'h00, e_lvl = 8'h00;
  bit          e_gpend = 0;
  int          e_dcnt = 0;
  int          m_st = 0;
  int          m_n = 0;
  logic [7:0]  prev_b = 8'h00;
  bit          prev_ok = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mdl(input logic [7:0] b);
    case (m_st)
      0: begin
        if (b[7]) e_conv = b;
        else if (b[6]) begin
          e_setup = b[5:0];
          m_st = (b[1:0] == 2'b10) ? 1 : (b[1:0] == 2'b11) ? 2 : 0;
        end else if (b[7:4] == 4'b0001) begin m_st = 3; m_n = 0; end
        else if (b == 8'h02) begin m_st = 4; m_n = 0; e_gpend = 0; end
      end
      1: begin e_uni = b; m_st = 0; end
      2: begin e_bip = b; m_st = 0; end
      3: begin
        m_acc = {m_acc[7:0], b}; m_n++;
        if (m_n == 2) begin e_dac = m_acc; e_dcnt++; m_st = 0; end
      end
      default: begin
        m_acc = {m_acc[7:0], b}; m_n++;
        if (m_n == 2) begin e_gnew = m_acc; e_gpend = 1; m_st = 0; end
      end
    endcase
  endtask

  task automatic send_bits(input logic [7:0] b, input int n, output logic [7:0] echo);
    echo = '0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi <= b[i];
      repeat (2) @(negedge clk);
      echo[i] = miso;
      sclk <= 1'b1;
      repeat (2) @(negedge clk);
      sclk <= 1'b0;
    end
  endtask

  task automatic send(input logic [7:0] b);
    logic [7:0] echo;
    send_bits(b, 8, echo);
    check("R10 miso echo", {24'h0, echo}, {24'h0, prev_ok ? prev_b : 8'h00});
    prev_b = b;
    prev_ok = 1;
    mdl(b);
  endtask

  task automatic begin_frame;
    cs_n <= 1'b0;
    repeat (2) @(negedge clk);
    prev_ok = 0;
  endtask

  task automatic end_frame;
    repeat (2) @(negedge clk);
    cs_n <= 1'b1;
    repeat (3) @(negedge clk);
    m_st = 0;
    if (e_gpend) begin {e_dir, e_lvl} = e_gnew; e_gpend = 0; end
  endtask

  task automatic compare_all(input string tag);
    check({tag, " R1 conv_cmd"},  {24'h0, conv_cmd}, {24'h0, e_conv});
    check({tag, " R2 setup_cfg"}, {26'h0, setup_cfg}, {26'h0, e_setup});
    check({tag, " R3 uni_mask"},  {24'h0, uni_mask}, {24'h0, e_uni});
    check({tag, " R4 bip_mask"},  {24'h0, bip_mask}, {24'h0, e_bip});
    check({tag, " R6 dac_word"},  {16'h0, dac_last}, {16'h0, e_dac});
    check({tag, " R6 dac count"}, dac_seen, e_dcnt);
    check({tag, " R7 gpio"},      {16'h0, gpio_dir, gpio_lvl}, {16'h0, e_dir, e_lvl});
  endtask

  function automatic logic [7:0] rand_byte();
    int k = $urandom_range(0, 6);
    case (k)
      0: return 8'h80 | 8'($urandom);
      1: return 8'h40 | 8'($urandom_range(0, 63));
      2: return 8'h40 | 8'($urandom_range(0, 15) << 2) | 8'h02;
      3: return 8'h10 | 8'($urandom_range(0, 15));
      4: return 8'h02;
      5: return 8'($urandom_range(0, 63)) & 8'h3F;
      default: return 8'($urandom);
    endcase
  endfunction

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] junk;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n <= 1'b1;
    repeat (2) @(negedge clk);
    compare_all("reset");
    check("R10 miso idle", {31'h0, miso}, 32'h0);

    // R3/R5/R11: setup then unipolar mask, then chained conversion
    begin_frame(); send(8'h4A); send(8'hA5); send(8'h83); end_frame();
    compare_all("directed uni");
    check("R3 uni pair bits", {24'h0, uni_mask}, 32'hA5);

    // R4 then R5: bipolar mask, then a setup with select 01 followed by a command
    begin_frame(); send(8'h77); send(8'h3C); send(8'h61); send(8'h9E); end_frame();
    compare_all("directed bip");

    // R8: mask phase cut by select; next frame's first byte is a command
    begin_frame(); send(8'h42); end_frame();
    begin_frame(); send(8'h85); end_frame();
    compare_all("R8 cut mask");
    check("R8 uni untouched", {24'h0, uni_mask}, 32'hA5);

    // R8: stray partial bits do not leak into next frame
    begin_frame(); send_bits(8'hFF, 5, junk); end_frame();
    begin_frame(); send(8'h03); end_frame();
    compare_all("R8 partial");

    // R9: unused codes
    begin_frame(); send(8'h00); send(8'h01); send(8'h2F); send(8'h0F); end_frame();
    compare_all("R9 unused");

    // R6: DAC word with ignored nibble
    begin_frame(); send(8'h1F); send(8'hBE); send(8'hEF); end_frame();
    compare_all("R6 dac");
    check("R6 dac exact", {16'h0, dac_word}, 32'hBEEF);

    // R7: GPIO held until select rises
    begin_frame(); send(8'h02); send(8'hF0); send(8'h5A);
    repeat (4) @(negedge clk);
    check("R7 gpio held in frame", {16'h0, gpio_dir, gpio_lvl}, 32'h0);
    end_frame();
    check("R7 gpio applied", {16'h0, gpio_dir, gpio_lvl}, 32'hF05A);
    compare_all("R7 gpio");

    // R8/R7: incomplete GPIO word discarded
    begin_frame(); send(8'h02); send(8'h11); end_frame();
    compare_all("R8 gpio short");

    for (int f = 0; f < 300; f++) begin
      int nb = $urandom_range(1, 6);
      begin_frame();
      for (int j = 0; j < nb; j++) send(rand_byte());
      end_frame();
      compare_all("random R11");
    end
    summary();
  end
endmodule